// File: doc/BRIEF.md
# Overlapped Block Pair Loader

This block accepts a continuous stream of real samples from one source and hands them to a downstream transform engine as pairs of blocks of length N. The pairs arrive on two parallel lanes, named real and imaginary. Every sample is written once into a circular store of three blocks. Two read pointers, kept N samples apart, then replay a window of 2N samples. The real lane carries the older block and the imaginary lane carries the newer one. The real lane is therefore the same stream as the imaginary lane, delayed by one block.

A mode code picks the overlap between consecutive blocks: none, one half or three quarters. With overlap, the plain pairs (1,2), (3,4) are interleaved with shifted pairs such as (1.5,2.5). Each pair is sent as N consecutive valid cycles. A start-of-frame flag marks the first pair of a frame. A load flag falls at the overlap point, which is where the next frame's data begins. A busy input from the consumer holds back the start of a transfer. An overrun flag reports when the next transfer becomes due while the current one is still running.

Top module: `ovl_pair_loader`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_first, out_load and overrun are low.
- R2: The mode code is captured while reset is high. 3'b001 selects no overlap, 3'b010 selects half overlap and 3'b011 selects three-quarter overlap. Every other code behaves as no overlap.
- R3: In pair i (0..N-1) of a transfer whose window starts at sample s (samples counted from 0 since reset), out_re carries sample s+i and out_im carries sample s+N+i. This holds across any number of wraps of the three-block store.
- R4: With no overlap, window starts are 0, 2N, 4N, and so on.
- R5: With half overlap, window starts follow g·2N and g·2N+N/2 for g = 0, 1, 2, …, which gives one transfer per N new samples.
- R6: With three-quarter overlap, window starts follow g·2N + j·N/4 for j = 0..3 and g = 0, 1, 2, ….
- R7: A transfer becomes due once sample s+2N-1 has been written. If the store is idle and busy is low, its first pair appears on the outputs two clock edges after the edge that captured that sample.
- R8: out_first is high on pair 0 of each transfer only.
- R9: out_load is high for the first N/K pairs of a transfer and low for the rest. K is 1, 2 or 4 for none, half and three-quarter overlap. With no overlap it therefore stays high for all N pairs.
- R10: Each transfer holds out_valid high for exactly N consecutive cycles, and there is at least one idle cycle between transfers.
- R11: While busy is high, no transfer starts. A transfer held back this way starts after busy falls, and none of its pairs is lost.
- R12: overrun is high in a cycle when a transfer is running and the next one is already due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures mode |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | W | Incoming real sample |
| mode | input | 3 | Overlap selection code |
| busy | input | 1 | Consumer not ready; holds back transfer starts |
| out_valid | output | 1 | A lane pair is present |
| out_re | output | W | Real lane sample (older block) |
| out_im | output | W | Imaginary lane sample (newer block) |
| out_first | output | 1 | First pair of a transfer |
| out_load | output | 1 | Load flag; its falling edge marks the overlap point |
| overrun | output | 1 | Next transfer due while one is running |

## Verification
Each overlap code is driven with a sample stream long enough to wrap the store several times. The streams are spaced so that transfers never collide, and every pair is compared against the window start predicted for that code. This separates the three schedules and the pointer offsets. A back-to-back feed in the no-overlap mode pins the two-edge start latency. An unlisted code is checked to follow the no-overlap schedule. A busy hold shows that a held transfer is delayed and not dropped. A full-rate feed at three-quarter overlap forces a transfer to fall due mid-transfer, which must raise overrun; the spaced runs must never raise it.

// File: rtl/ovl_pair_loader_pkg.sv
package ovl_pair_loader_pkg;

  // Overlap kind; the numeric value is the shift that gives N/K.
  typedef enum logic [1:0] {
    OVL_NONE = 2'd0,
    OVL_HALF = 2'd1,
    OVL_QTR  = 2'd2
  } ovl_e;

  localparam logic [2:0] MODE_HALF = 3'b010;
  localparam logic [2:0] MODE_QTR  = 3'b011;

  function automatic ovl_e decode_mode(input logic [2:0] code);
    case (code)
      MODE_HALF: return OVL_HALF;
      MODE_QTR:  return OVL_QTR;
      default:   return OVL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ovl_store.sv
module ovl_store #(
  parameter int W  = 16,
  parameter int N  = 64,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  localparam int DEPTH = 3 * N;

  logic [W-1:0]  mem_a [DEPTH];
  logic [W-1:0]  mem_b [DEPTH];
  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
    end else if (wr) begin
      wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  // Two copies, one read port each, so each maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (wr) begin
      mem_a[wr_ptr] <= wdata;
      mem_b[wr_ptr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      qa <= mem_a[ra];
      qb <= mem_b[rb];
    end
  end

endmodule

// File: rtl/ovl_sched.sv
module ovl_sched
  import ovl_pair_loader_pkg::*;
#(
  parameter int N  = 64,
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  ovl_e          ovl,
  input  logic          busy,
  input  logic          active,
  output logic          start,
  output logic          due,
  output logic [AW-1:0] base,
  output logic [CW-1:0] sub
);
  localparam int DEPTH = 3 * N;

  logic [CW-1:0] avail;
  logic [CW-1:0] avail_nx;
  logic [CW-1:0] step;
  logic [1:0]    phase;
  logic [1:0]    last_ph;
  logic          last;
  logic [AW:0]   bsum;

  always_comb begin
    sub = CW'(N) >> ovl;
    case (ovl)
      OVL_HALF: last_ph = 2'd1;
      OVL_QTR:  last_ph = 2'd3;
      default:  last_ph = 2'd0;
    endcase
    last  = (phase == last_ph);
    // Within a group the window slides by N/K; the last step jumps to the next 2N group.
    step  = last ? (CW'(N) + sub) : sub;
    due   = (avail >= CW'(2 * N));
    start = due && !busy && !active;
    avail_nx = avail + CW'(wr) - (start ? step : '0);
    bsum  = {1'b0, base} + (AW + 1)'(step);
    if (bsum >= (AW + 1)'(DEPTH)) bsum = bsum - (AW + 1)'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= '0;
      phase <= '0;
      base  <= '0;
    end else begin
      avail <= avail_nx;
      if (start) begin
        phase <= last ? 2'd0 : phase + 2'd1;
        base  <= bsum[AW-1:0];
      end
    end
  end

endmodule

// File: rtl/ovl_reader.sv
module ovl_reader #(
  parameter int N  = 64,
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] sub,
  output logic          active,
  output logic [AW-1:0] ra,
  output logic [AW-1:0] rb,
  output logic          v,
  output logic          first,
  output logic          load
);
  localparam int DEPTH = 3 * N;
  localparam int IW    = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;
  logic [AW:0]   bsum;

  function automatic logic [AW-1:0] inc_wrap(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_comb begin
    bsum = {1'b0, base} + (AW + 1)'(N);
    if (bsum >= (AW + 1)'(DEPTH)) bsum = bsum - (AW + 1)'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      ra     <= '0;
      rb     <= '0;
      v      <= 1'b0;
      first  <= 1'b0;
      load   <= 1'b0;
    end else begin
      // Flags are delayed one stage to line up with the registered RAM read.
      v     <= active;
      first <= active && (idx == '0);
      load  <= active && (CW'(idx) < sub);
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
        ra     <= base;
        rb     <= bsum[AW-1:0];
      end else if (active) begin
        ra  <= inc_wrap(ra);
        rb  <= inc_wrap(rb);
        idx <= idx + 1'b1;
        if (idx == IW'(N - 1)) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ovl_pair_loader.sv
module ovl_pair_loader
  import ovl_pair_loader_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [2:0]   mode,
  input  logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im,
  output logic         out_first,
  output logic         out_load,
  output logic         overrun
);
  localparam int DEPTH = 3 * N;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(4 * N) + 1;

  ovl_e          ovl_q;
  logic          start;
  logic          due;
  logic          active;
  logic [AW-1:0] base;
  logic [CW-1:0] sub;
  logic [AW-1:0] ra;
  logic [AW-1:0] rb;

  always_ff @(posedge clk) begin
    if (rst) ovl_q <= decode_mode(mode);
  end

  ovl_store #(.W(W), .N(N), .AW(AW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr    (in_valid),
    .wdata (in_data),
    .rd_en (active),
    .ra    (ra),
    .rb    (rb),
    .qa    (out_re),
    .qb    (out_im)
  );

  ovl_sched #(.N(N), .AW(AW), .CW(CW)) u_sched (
    .clk    (clk),
    .rst    (rst),
    .wr     (in_valid),
    .ovl    (ovl_q),
    .busy   (busy),
    .active (active),
    .start  (start),
    .due    (due),
    .base   (base),
    .sub    (sub)
  );

  ovl_reader #(.N(N), .AW(AW), .CW(CW)) u_reader (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .base   (base),
    .sub    (sub),
    .active (active),
    .ra     (ra),
    .rb     (rb),
    .v      (out_valid),
    .first  (out_first),
    .load   (out_load)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else     overrun <= active && due;
  end

endmodule

// File: rtl/ovl_pair_loader_chk.sv
module ovl_pair_loader_chk #(
  parameter int N = 64
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic out_valid,
  input logic out_first,
  input logic out_load,
  input logic overrun
);
  localparam int RW = $clog2(N + 1) + 1;

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)            run <= '0;
    else if (out_valid) run <= run + 1'b1;
    else                run <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_first && !out_load && !overrun));

  // R8
  first_lead_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> (out_valid && run == '0));

  // R8
  first_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_first);

  // R9
  load_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    out_load |-> out_valid);

  // R9
  load_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_load);

  // R9
  load_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first && !$past(out_load)) |-> !out_load);

  // R10
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run < RW'(N)));

  // R10
  run_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && run != '0) |-> (run == RW'(N)));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> !$past(busy, 2));

  // R12
  overrun_active_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> out_valid);

endmodule

bind ovl_pair_loader ovl_pair_loader_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_load  (out_load),
  .overrun   (overrun)
);

// File: tb/ovl_pair_loader_test.sv
module ovl_pair_loader_test;
  localparam int W = 16;
  localparam int N = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [2:0]   mode = 3'b001;
  logic         busy = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_re;
  logic [W-1:0] out_im;
  logic         out_first;
  logic         out_load;
  logic         overrun;

  ovl_pair_loader #(.W(W), .N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .busy(busy), .out_valid(out_valid), .out_re(out_re),
    .out_im(out_im), .out_first(out_first), .out_load(out_load),
    .overrun(overrun)
  );

  int checks = 0;
  int fails = 0;
  logic [2*W+1:0] q[$];
  bit    sb_on = 1'b1;
  string tag = "R3";
  int    n_wr, grp, ph, ksh, vcount, ovr_seen;

  function automatic logic [W-1:0] smp(input int k);
    return W'(k * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input int sh);
    @(negedge clk);
    mode = m; rst = 1'b1; busy = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    q.delete();
    n_wr = 0; grp = 0; ph = 0; ksh = sh; vcount = 0; ovr_seen = 0;
    rst = 1'b0;
  endtask

  // Scoreboard driver side: push the N pairs of the transfer that just became due.
  task automatic push_pairs();
    int s;
    s = grp * 2 * N + ph * (N >> ksh);
    for (int i = 0; i < N; i++)
      q.push_back({smp(s + i), smp(s + N + i), (i == 0) ? 1'b1 : 1'b0,
                   (i < (N >> ksh)) ? 1'b1 : 1'b0});
    ph++;
    if (ph == (1 << ksh)) begin ph = 0; grp++; end
  endtask

  task automatic feed(input int cnt, input int gap);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = smp(n_wr);
      n_wr++;
      if (n_wr == grp * 2 * N + ph * (N >> ksh) + 2 * N) push_pairs();
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((q.size() != 0 || out_valid) && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(q.size() == 0, tag, "pairs still expected", q.size(), 0);
  endtask

  // Scoreboard monitor side.
  always @(negedge clk) begin
    if (!rst) begin
      if (overrun) ovr_seen++;
      if (out_valid) begin
        vcount++;
        if (sb_on) begin
          if (q.size() == 0) begin
            check(1'b0, tag, "unexpected pair", {out_re, out_im, out_first, out_load}, 0);
          end else begin
            logic [2*W+1:0] e;
            e = q.pop_front();
            check({out_re, out_im, out_first, out_load} == e, tag,
                  "pair {re,im,first,load}", {out_re, out_im, out_first, out_load}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !out_first && !out_load && !overrun, "R1", "flags in reset",
          {out_valid, out_first, out_load, overrun}, 0);
    rst = 1'b0;

    // No overlap: R3/R4/R7/R8/R9
    do_reset(3'b001, 0);
    @(negedge clk);
    check(!out_valid && !out_first && !out_load && !overrun, "R1", "flags after reset",
          {out_valid, out_first, out_load, overrun}, 0);
    tag = "R3/R4/R8/R9";
    feed(2 * N, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "valid one edge after due", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7", "valid two edges after due", out_valid, 1);
    feed(6 * N, 2);
    drain();
    check(vcount == 4 * N, "R10", "valid cycles, no overlap", vcount, 4 * N);
    check(ovr_seen == 0, "R12", "no overrun when spaced", ovr_seen, 0);

    // Half overlap: R5
    do_reset(3'b010, 1);
    tag = "R3/R5/R8/R9";
    feed(8 * N, 3);
    drain();
    check(vcount == 7 * N, "R5", "valid cycles, half overlap", vcount, 7 * N);
    check(ovr_seen == 0, "R12", "no overrun when spaced", ovr_seen, 0);

    // Three-quarter overlap: R6
    do_reset(3'b011, 2);
    tag = "R3/R6/R8/R9";
    feed(8 * N, 6);
    drain();
    check(vcount == 13 * N, "R6", "valid cycles, 3/4 overlap", vcount, 13 * N);
    check(ovr_seen == 0, "R12", "no overrun when spaced", ovr_seen, 0);

    // Unlisted code behaves as no overlap: R2
    do_reset(3'b111, 0);
    tag = "R2";
    feed(4 * N, 1);
    drain();
    check(vcount == 2 * N, "R2", "valid cycles, code 111", vcount, 2 * N);

    // Busy holds back the start: R11
    do_reset(3'b010, 1);
    tag = "R11";
    busy = 1'b1;
    feed(2 * N, 1);
    repeat (20) @(negedge clk);
    check(vcount == 0, "R11", "no pairs while busy", vcount, 0);
    busy = 1'b0;
    drain();
    check(vcount == N, "R11", "held transfer delivered", vcount, N);

    // Full-rate 3/4 overlap forces a due transfer mid-transfer: R12
    do_reset(3'b011, 2);
    tag = "R12";
    sb_on = 1'b0;
    feed(3 * N, 0);
    repeat (40) @(negedge clk);
    check(ovr_seen > 0, "R12", "overrun seen at full rate", ovr_seen, 1);
    q.delete();
    sb_on = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule